// File: doc/BRIEF.md
# Masked SIMD AND-NOT lane unit

This execution unit works on a vector register of eight 64-bit lanes. In every lane that it writes, it complements the first source and ANDs the complement with the second source. A form select picks one of three ways the lanes are filled:

- **Legacy two-operand form.** The old destination value doubles as the first source.
- **Plain three-operand form.** No write mask is applied.
- **Masked three-operand form.** A per-lane write mask applies. Lanes whose mask bit is clear can either merge or zero. The second source can be replaced by its own lane 0 in every lane.

A vector-length select limits how many lanes are active. Lanes above that length are cleared in the three-operand forms.

The caller presents all operands together with a single-cycle valid strobe. The result comes back one clock later from a register, together with a valid flag. The register holds its last value between operations.

Top module: `andn_unit`

## Requirements
- R1: In the plain form (form_sel = 1), every lane below the vector length outputs `~src_a[lane] & src_b[lane]`, taken bitwise over the 64 bits of the lane. Lane n occupies bits [64n+63:64n].
- R2: vlen_sel encodes the active lane count as follows: 0 gives 2 lanes, 1 gives 4 lanes, 2 gives 8 lanes. The unused code 3 also gives 8 lanes.
- R3: In the legacy form (form_sel = 0), lanes 0 and 1 output `~dst_old[lane] & src_b[lane]`. Lanes 2 to 7 output their dst_old value unchanged. src_a and vlen_sel have no effect in this form.
- R4: In the plain form, every lane at or above the vector length outputs zero. Form code 3 behaves exactly like the plain form.
- R5: In the masked form (form_sel = 2), a lane below the vector length whose lane_mask bit is 1 outputs the AND-NOT result. Mask bit n controls lane n.
- R6: In the masked form, a lane below the vector length whose mask bit is 0 outputs zero when zero_en is 1. When zero_en is 0, it outputs its dst_old value.
- R7: In the masked form, lanes at or above the vector length output zero whatever their mask bits are.
- R8: In the masked form with bcast_en = 1, every lane uses `src_b[63:0]` in place of its own lane of src_b.
- R9: lane_mask, zero_en and bcast_en have no effect in the legacy and plain forms.
- R10: The output timing is as follows:
  - out_valid is 1 in the cycle after a clock edge that samples in_valid = 1, and 0 otherwise.
  - out_data changes only on such an edge.
  - out_data holds its value after an edge that samples in_valid = 0.
- R11: A clock edge that samples rst = 1 clears out_valid and out_data to zero. This reset is synchronous and active high, and it overrides in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| form_sel | input | 2 | 0 legacy, 1 plain, 2 masked, 3 as plain |
| vlen_sel | input | 2 | 0: 2 lanes, 1: 4 lanes, 2/3: 8 lanes |
| zero_en | input | 1 | Masked form: zero the lanes whose mask bit is clear |
| bcast_en | input | 1 | Masked form: use lane 0 of src_b in all lanes |
| lane_mask | input | 8 | Per-lane write enable for the masked form |
| dst_old | input | 512 | Previous destination value |
| src_a | input | 512 | First source (the complemented one) |
| src_b | input | 512 | Second source |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Registered result |

## Verification
The hardest cycle combines three effects: vector-length truncation, per-lane masking and broadcast. A lane whose mask bit is set can still be above the vector length and must come out zero. At the same time, lanes below the length mix write, merge and zero actions, and all of them draw on lane 0 of src_b.

The bench provokes this with masked operations at every vector length. It uses masks that have bits set above the length, and turns zeroing and broadcast on and off in the same cycle. A behavioural lane-by-lane model computes the expected register value, and the bench compares it on every clock.

// File: rtl/andn_pkg.sv
package andn_pkg;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'd0,
    FORM_PLAIN  = 2'd1,
    FORM_MASKED = 2'd2,
    FORM_ALT    = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    ACT_RESULT = 2'd0,
    ACT_KEEP   = 2'd1,
    ACT_ZERO   = 2'd2
  } lane_act_e;

  localparam int unsigned LEGACY_LANES = 2;

  // Active lane count for a vector-length code, clipped to the lane count.
  function automatic int unsigned active_lanes(input logic [1:0] vsel,
                                               input int unsigned max_lanes);
    int unsigned n;
    case (vsel)
      2'd0:    n = 2;
      2'd1:    n = 4;
      default: n = 8;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

endpackage

// File: rtl/andn_lane_ctrl.sv
module andn_lane_ctrl
  import andn_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic [1:0]                  form_sel,
  input  logic [1:0]                  vlen_sel,
  input  logic [LANES-1:0]            lane_mask,
  input  logic                        zero_en,
  output lane_act_e [LANES-1:0]       act_o
);

  int unsigned n_act;
  form_e       form;

  always_comb begin
    n_act = active_lanes(vlen_sel, LANES);
    form  = form_e'(form_sel);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (form)
        FORM_LEGACY: act_o[i] = (i < LEGACY_LANES) ? ACT_RESULT : ACT_KEEP;
        FORM_MASKED: begin
          if (i >= n_act)       act_o[i] = ACT_ZERO;
          else if (lane_mask[i]) act_o[i] = ACT_RESULT;
          else if (zero_en)     act_o[i] = ACT_ZERO;
          else                  act_o[i] = ACT_KEEP;
        end
        default:     act_o[i] = (i < n_act) ? ACT_RESULT : ACT_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/andn_operand_sel.sv
module andn_operand_sel
  import andn_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 64,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic [1:0]        form_sel,
  input  logic              bcast_en,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] inv_opnd,
  output logic [DATA_W-1:0] and_opnd
);

  logic legacy;
  logic bcast;

  always_comb begin
    legacy = (form_e'(form_sel) == FORM_LEGACY);
    bcast  = (form_e'(form_sel) == FORM_MASKED) && bcast_en;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      inv_opnd[i*LANE_W +: LANE_W] = legacy ? dst_old[i*LANE_W +: LANE_W]
                                            : src_a[i*LANE_W +: LANE_W];
      and_opnd[i*LANE_W +: LANE_W] = bcast ? src_b[LANE_W-1:0]
                                           : src_b[i*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/andn_lane_datapath.sv
module andn_lane_datapath
  import andn_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 64,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  lane_act_e [LANES-1:0] act,
  input  logic [DATA_W-1:0]     inv_opnd,
  input  logic [DATA_W-1:0]     and_opnd,
  input  logic [DATA_W-1:0]     dst_old,
  output logic [DATA_W-1:0]     next_data
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] res;
    always_comb begin
      res = ~inv_opnd[i*LANE_W +: LANE_W] & and_opnd[i*LANE_W +: LANE_W];
      case (act[i])
        ACT_RESULT: next_data[i*LANE_W +: LANE_W] = res;
        ACT_KEEP:   next_data[i*LANE_W +: LANE_W] = dst_old[i*LANE_W +: LANE_W];
        default:    next_data[i*LANE_W +: LANE_W] = '0;
      endcase
    end
  end

endmodule

// File: rtl/andn_unit.sv
module andn_unit
  import andn_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 64,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        form_sel,
  input  logic [1:0]        vlen_sel,
  input  logic              zero_en,
  input  logic              bcast_en,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  lane_act_e [LANES-1:0] act;
  logic [DATA_W-1:0]     inv_opnd;
  logic [DATA_W-1:0]     and_opnd;
  logic [DATA_W-1:0]     next_data;

  andn_lane_ctrl #(.LANES(LANES)) u_ctrl (
    .form_sel  (form_sel),
    .vlen_sel  (vlen_sel),
    .lane_mask (lane_mask),
    .zero_en   (zero_en),
    .act_o     (act)
  );

  andn_operand_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_opsel (
    .form_sel (form_sel),
    .bcast_en (bcast_en),
    .dst_old  (dst_old),
    .src_a    (src_a),
    .src_b    (src_b),
    .inv_opnd (inv_opnd),
    .and_opnd (and_opnd)
  );

  andn_lane_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .act       (act),
    .inv_opnd  (inv_opnd),
    .and_opnd  (and_opnd),
    .dst_old   (dst_old),
    .next_data (next_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end

endmodule

// File: rtl/andn_unit_chk.sv
module andn_unit_chk
  import andn_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 64,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        form_sel,
  input logic [1:0]        vlen_sel,
  input logic              zero_en,
  input logic              bcast_en,
  input logic [LANES-1:0]  lane_mask,
  input logic [DATA_W-1:0] dst_old,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  localparam int unsigned LO_W = 2 * LANE_W;

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_plain_lane0_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_PLAIN) |=>
      out_data[LANE_W-1:0] == (~$past(src_a[LANE_W-1:0]) & $past(src_b[LANE_W-1:0])));

  assert_legacy_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_LEGACY) |=>
      out_data[DATA_W-1:LO_W] == $past(dst_old[DATA_W-1:LO_W]));

  assert_plain_short_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_PLAIN && vlen_sel == 2'd0) |=>
      out_data[DATA_W-1:LO_W] == '0);

  assert_masked_short_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_MASKED && vlen_sel == 2'd0) |=>
      out_data[DATA_W-1:LO_W] == '0);

  assert_masked_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_MASKED && zero_en && lane_mask == '0) |=>
      out_data == '0);

  assert_bcast_lane1_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_MASKED && bcast_en && lane_mask[1]) |=>
      out_data[2*LANE_W-1:LANE_W] ==
        (~$past(src_a[2*LANE_W-1:LANE_W]) & $past(src_b[LANE_W-1:0])));

endmodule

bind andn_unit andn_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .form_sel  (form_sel),
  .vlen_sel  (vlen_sel),
  .zero_en   (zero_en),
  .bcast_en  (bcast_en),
  .lane_mask (lane_mask),
  .dst_old   (dst_old),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/andn_unit_tb.sv
module andn_unit_tb;

  localparam int L = 8;
  localparam int W = 64;
  localparam int D = L * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   form_sel = '0;
  logic [1:0]   vlen_sel = '0;
  logic         zero_en = 1'b0;
  logic         bcast_en = 1'b0;
  logic [L-1:0] lane_mask = '0;
  logic [D-1:0] dst_old = '0;
  logic [D-1:0] src_a = '0;
  logic [D-1:0] src_b = '0;
  logic         out_valid;
  logic [D-1:0] out_data;

  always #5 clk = ~clk;

  andn_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel),
    .vlen_sel(vlen_sel), .zero_en(zero_en), .bcast_en(bcast_en),
    .lane_mask(lane_mask), .dst_old(dst_old), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic         exp_valid = 1'b0;
  logic [D-1:0] exp_data  = '0;

  function automatic logic [D-1:0] rnd512();
    logic [D-1:0] v;
    for (int k = 0; k < D / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Behavioural model of one operation, lane by lane.
  function automatic logic [D-1:0] model(int form, int vsel, bit z, bit bc,
      logic [L-1:0] m, logic [D-1:0] d, logic [D-1:0] a, logic [D-1:0] b);
    logic [D-1:0] r;
    int n;
    n = (vsel == 0) ? 2 : (vsel == 1) ? 4 : 8;
    for (int l = 0; l < L; l++) begin
      logic [W-1:0] dl, al, bl, res;
      dl = d[l*W +: W];
      al = a[l*W +: W];
      bl = (form == 2 && bc) ? b[W-1:0] : b[l*W +: W];
      if (form == 0)      res = (l < 2) ? (~dl & b[l*W +: W]) : dl;
      else if (form == 2) res = (l >= n) ? '0 : m[l] ? (~al & bl) : z ? '0 : dl;
      else                res = (l < n) ? (~al & bl) : '0;
      r[l*W +: W] = res;
    end
    return r;
  endfunction

  task automatic check_out(string req);
    checks++;
    if (out_valid !== exp_valid || out_data !== exp_data) begin
      fails++;
      $display("FAIL %s: got valid=%0b data=%h expected valid=%0b data=%h",
               req, out_valid, out_data, exp_valid, exp_data);
    end
  endtask

  task automatic issue(int form, int vsel, bit z, bit bc, logic [L-1:0] m, string req);
    @(negedge clk);
    in_valid  = 1'b1;
    form_sel  = 2'(form);
    vlen_sel  = 2'(vsel);
    zero_en   = z;
    bcast_en  = bc;
    lane_mask = m;
    dst_old   = rnd512();
    src_a     = rnd512();
    src_b     = rnd512();
    exp_valid = 1'b1;
    exp_data  = model(form, vsel, z, bc, m, dst_old, src_a, src_b);
    @(posedge clk);
    #1;
    check_out(req);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    in_valid  = 1'b0;
    form_sel  = 2'($urandom);
    lane_mask = 8'($urandom);
    dst_old   = rnd512();
    src_a     = rnd512();
    src_b     = rnd512();
    exp_valid = 1'b0;
    @(posedge clk);
    #1;
    check_out(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check_out("R11 reset state");
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;

    for (int v = 0; v < 4; v++) issue(1, v, 0, 0, 8'h00, "R1 R2 R4 plain form");
    issue(3, 0, 0, 0, 8'h00, "R4 form code 3 as plain");
    issue(3, 2, 1, 1, 8'h0F, "R4 R9 form code 3 flags ignored");
    issue(1, 1, 1, 1, 8'h00, "R9 plain ignores mask zero bcast");
    issue(0, 0, 0, 0, 8'hFF, "R3 legacy form");
    issue(0, 2, 1, 1, 8'h00, "R3 R9 legacy ignores vlen mask flags");
    issue(2, 2, 0, 0, 8'hFF, "R5 masked all lanes");
    issue(2, 2, 0, 0, 8'hA5, "R6 masked merge");
    issue(2, 2, 1, 0, 8'hA5, "R6 masked zeroing");
    issue(2, 0, 0, 0, 8'hFF, "R7 masked short length");
    issue(2, 1, 0, 0, 8'hF0, "R7 mask above length");
    issue(2, 2, 0, 1, 8'hFF, "R8 broadcast");
    for (int v = 0; v < 4; v++) issue(2, v, 1, 1, 8'hF5, "R5 R7 R8 combined");
    idle("R10 hold after idle");
    idle("R10 second idle");
    for (int k = 0; k < 60; k++)
      issue($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            8'($urandom), "R1 R3 R5 R6 R8 random");
    idle("R10 hold after burst");

    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    exp_valid = 1'b0;
    exp_data = '0;
    @(posedge clk);
    #1;
    check_out("R11 reset overrides valid");
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    issue(2, 2, 0, 0, 8'h3C, "R6 merge after reset");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule